// File: doc/BRIEF.md
# Register Alias Table with Result Snoop

This block keeps, for every architectural register, either a committed value or the tag of the in-flight operation that will produce the register's next value. A rename request supplies two source register indices and one destination index. For each source the block reports a ready value or, if the value is still pending, the tag to wait for. The destination entry is then claimed by the new producer tag. A result bus delivers tag/value pairs as operations finish. An entry captures a result only if it is still waiting on exactly that tag. Results from older writers whose register has since been renamed again are therefore dropped.

The rename side is gated by a reservation-station-free input, so the table never records a producer that has nowhere to wait. A debug read port returns the raw state of any entry. All outputs are registered and appear on the cycle after the request.

Top module: `rename_alias_table`

## Requirements
- R1: After reset every entry is valid, with value 0 and tag 0. After reset the rename outputs and the debug outputs read 0.
- R2: An accepted rename (`ren_en` and `rs_free` both high) marks the destination entry pending and stores `ren_tag` in it.
- R3: A source lookup reports `ready`=1 and the entry value when the entry is valid. Otherwise it reports `ready`=0 and the stored tag. The unused field of the pair reads 0.
- R4: A result whose tag equals the stored tag of a pending entry writes its value into that entry and makes it valid.
- R5: A result whose tag differs from an entry's stored tag leaves that entry unchanged. A valid entry also ignores every result. This holds for an older writer's result after two renames of the same register.
- R6: When `rs_free` is low, a rename request changes no entry, `ren_ok` stays 0 and the source outputs hold their previous values.
- R7: When an accepted rename and a matching result target the same entry in one cycle, the rename wins: the entry stays pending with the new tag.
- R8: A source whose pending tag matches the result presented in the same cycle is reported ready, carrying the result value.
- R9: A source that names the destination of the same request sees the mapping from before that request.
- R10: Lookup results and `ren_ok` appear on the clock edge that samples the request. `ren_ok` is high for exactly the cycle after each accepted rename.
- R11: The debug port reports the valid flag, value and tag that the selected entry held before the sampling edge, one cycle later.
- R12: Two sources that name the same register receive identical results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_en | input | 1 | Rename request |
| rs_free | input | 1 | A reservation station is available |
| ren_src_a | input | IDX_W | First source register |
| ren_src_b | input | IDX_W | Second source register |
| ren_dst | input | IDX_W | Destination register |
| ren_tag | input | TAG_W | Tag of the new producer |
| bc_valid | input | 1 | Result bus carries a result |
| bc_tag | input | TAG_W | Tag of the result |
| bc_data | input | DATA_W | Value of the result |
| dbg_sel | input | IDX_W | Register selected for debug read |
| ren_ok | output | 1 | Previous cycle's rename was accepted |
| src_a_ready | output | 1 | First source value available |
| src_a_data | output | DATA_W | First source value (0 if pending) |
| src_a_tag | output | TAG_W | First source pending tag (0 if ready) |
| src_b_ready | output | 1 | Second source value available |
| src_b_data | output | DATA_W | Second source value (0 if pending) |
| src_b_tag | output | TAG_W | Second source pending tag (0 if ready) |
| dbg_valid | output | 1 | Valid flag of the selected entry |
| dbg_data | output | DATA_W | Value of the selected entry |
| dbg_tag | output | TAG_W | Tag of the selected entry |

## Verification
The hardest case to reach from the ports is a stale result. It needs a register renamed twice while its first producer is still in flight, and then the first producer's tag broadcast. Random tags would almost never line up that way. A directed sequence therefore issues two renames of one register back to back and then broadcasts the older tag. The same sequence covers the rename-versus-result collision and same-cycle bypass. In the random phase, half of all results carry a tag copied from a randomly chosen entry of the bench's model, so matches and collisions occur often.

// File: rtl/rat_pkg.sv
package rat_pkg;
  localparam int RAT_REGS   = 8;
  localparam int RAT_DATA_W = 16;
  localparam int RAT_TAG_W  = 4;
endpackage

// File: rtl/rat_entry.sv
module rat_entry #(
  parameter int DATA_W = rat_pkg::RAT_DATA_W,
  parameter int TAG_W  = rat_pkg::RAT_TAG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_claim,
  input  logic [TAG_W-1:0]  claim_tag,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  output logic              valid_q,
  output logic [TAG_W-1:0]  tag_q,
  output logic [DATA_W-1:0] data_q
);
  logic capture;
  assign capture = bc_valid && !valid_q && (tag_q == bc_tag);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b1;
      tag_q   <= '0;
      data_q  <= '0;
    end else if (wr_claim) begin
      valid_q <= 1'b0;
      tag_q   <= claim_tag;
    end else if (capture) begin
      valid_q <= 1'b1;
      data_q  <= bc_data;
    end
  end

  assert_claim_wins_R7: assert property (@(posedge clk) disable iff (rst)
    wr_claim |=> (!valid_q && tag_q == $past(claim_tag)));

  assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
    (bc_valid && !wr_claim && !valid_q && tag_q == bc_tag)
      |=> (valid_q && data_q == $past(bc_data)));

  assert_stale_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (bc_valid && !wr_claim && tag_q != bc_tag)
      |=> ($stable(valid_q) && $stable(tag_q) && $stable(data_q)));
endmodule

// File: rtl/rat_lookup.sv
module rat_lookup #(
  parameter int NUM_REGS = rat_pkg::RAT_REGS,
  parameter int DATA_W   = rat_pkg::RAT_DATA_W,
  parameter int TAG_W    = rat_pkg::RAT_TAG_W,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0]             valid_v,
  input  logic [NUM_REGS-1:0][TAG_W-1:0]  tag_v,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] data_v,
  input  logic [IDX_W-1:0]                sel,
  input  logic                            bc_valid,
  input  logic [TAG_W-1:0]                bc_tag,
  input  logic [DATA_W-1:0]               bc_data,
  output logic                            rdy,
  output logic [DATA_W-1:0]               data,
  output logic [TAG_W-1:0]                tag
);
  always_comb begin
    rdy  = 1'b0;
    data = '0;
    tag  = '0;
    if (valid_v[sel]) begin
      rdy  = 1'b1;
      data = data_v[sel];
    end else if (bc_valid && bc_tag == tag_v[sel]) begin
      rdy  = 1'b1;
      data = bc_data;
    end else begin
      tag  = tag_v[sel];
    end
  end
endmodule

// File: rtl/rename_alias_table.sv
module rename_alias_table #(
  parameter int NUM_REGS = rat_pkg::RAT_REGS,
  parameter int DATA_W   = rat_pkg::RAT_DATA_W,
  parameter int TAG_W    = rat_pkg::RAT_TAG_W,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ren_en,
  input  logic              rs_free,
  input  logic [IDX_W-1:0]  ren_src_a,
  input  logic [IDX_W-1:0]  ren_src_b,
  input  logic [IDX_W-1:0]  ren_dst,
  input  logic [TAG_W-1:0]  ren_tag,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  input  logic [IDX_W-1:0]  dbg_sel,
  output logic              ren_ok,
  output logic              src_a_ready,
  output logic [DATA_W-1:0] src_a_data,
  output logic [TAG_W-1:0]  src_a_tag,
  output logic              src_b_ready,
  output logic [DATA_W-1:0] src_b_data,
  output logic [TAG_W-1:0]  src_b_tag,
  output logic              dbg_valid,
  output logic [DATA_W-1:0] dbg_data,
  output logic [TAG_W-1:0]  dbg_tag
);
  logic                            ren_go;
  logic [NUM_REGS-1:0]             ent_valid;
  logic [NUM_REGS-1:0][TAG_W-1:0]  ent_tag;
  logic [NUM_REGS-1:0][DATA_W-1:0] ent_data;

  assign ren_go = ren_en && rs_free;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
    rat_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_ent (
      .clk       (clk),
      .rst       (rst),
      .wr_claim  (ren_go && (ren_dst == IDX_W'(i))),
      .claim_tag (ren_tag),
      .bc_valid  (bc_valid),
      .bc_tag    (bc_tag),
      .bc_data   (bc_data),
      .valid_q   (ent_valid[i]),
      .tag_q     (ent_tag[i]),
      .data_q    (ent_data[i])
    );
  end

  logic              la_rdy, lb_rdy;
  logic [DATA_W-1:0] la_data, lb_data;
  logic [TAG_W-1:0]  la_tag, lb_tag;

  rat_lookup #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_look_a (
    .valid_v(ent_valid), .tag_v(ent_tag), .data_v(ent_data), .sel(ren_src_a),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .rdy(la_rdy), .data(la_data), .tag(la_tag)
  );

  rat_lookup #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_look_b (
    .valid_v(ent_valid), .tag_v(ent_tag), .data_v(ent_data), .sel(ren_src_b),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .rdy(lb_rdy), .data(lb_data), .tag(lb_tag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ren_ok      <= 1'b0;
      src_a_ready <= 1'b0;
      src_a_data  <= '0;
      src_a_tag   <= '0;
      src_b_ready <= 1'b0;
      src_b_data  <= '0;
      src_b_tag   <= '0;
      dbg_valid   <= 1'b0;
      dbg_data    <= '0;
      dbg_tag     <= '0;
    end else begin
      ren_ok    <= ren_go;
      dbg_valid <= ent_valid[dbg_sel];
      dbg_data  <= ent_data[dbg_sel];
      dbg_tag   <= ent_tag[dbg_sel];
      if (ren_go) begin
        src_a_ready <= la_rdy;
        src_a_data  <= la_data;
        src_a_tag   <= la_tag;
        src_b_ready <= lb_rdy;
        src_b_data  <= lb_data;
        src_b_tag   <= lb_tag;
      end
    end
  end

  assert_gate_R6: assert property (@(posedge clk) disable iff (rst)
    ren_ok |-> $past(ren_en && rs_free));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !(ren_en && rs_free) |=> ($stable(src_a_data) && $stable(src_a_tag) && $stable(src_b_data)
                            && $stable(src_b_tag)));

  assert_pair_excl_R3: assert property (@(posedge clk) disable iff (rst)
    (src_a_ready ? (src_a_tag == '0) : (src_a_data == '0)));
endmodule

// File: tb/rename_alias_table_test.sv
`timescale 1ns/1ps
module rename_alias_table_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic ren_en = 0, rs_free = 0, bc_valid = 0;
  logic [2:0] ren_src_a = 0, ren_src_b = 0, ren_dst = 0, dbg_sel = 0;
  logic [3:0] ren_tag = 0, bc_tag = 0;
  logic [15:0] bc_data = 0;
  logic ren_ok, src_a_ready, src_b_ready, dbg_valid;
  logic [15:0] src_a_data, src_b_data, dbg_data;
  logic [3:0] src_a_tag, src_b_tag, dbg_tag;

  rename_alias_table uut (
    .clk(clk), .rst(rst), .ren_en(ren_en), .rs_free(rs_free),
    .ren_src_a(ren_src_a), .ren_src_b(ren_src_b), .ren_dst(ren_dst), .ren_tag(ren_tag),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data), .dbg_sel(dbg_sel),
    .ren_ok(ren_ok), .src_a_ready(src_a_ready), .src_a_data(src_a_data), .src_a_tag(src_a_tag),
    .src_b_ready(src_b_ready), .src_b_data(src_b_data), .src_b_tag(src_b_tag),
    .dbg_valid(dbg_valid), .dbg_data(dbg_data), .dbg_tag(dbg_tag)
  );

  int total = 0, bad = 0;
  bit m_v [8];
  logic [3:0] m_t [8];
  logic [15:0] m_d [8];
  bit e_ok, e_ar, e_br, e_dv;
  logic [15:0] e_ad, e_bd, e_dd;
  logic [3:0] e_at, e_bt, e_dt;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void look(input logic [2:0] s, input bit cv, input logic [3:0] ct,
                               input logic [15:0] cd, output bit r, output logic [15:0] d,
                               output logic [3:0] t);
    r = 0; d = 0; t = 0;
    if (m_v[s]) begin r = 1; d = m_d[s]; end
    else if (cv && ct == m_t[s]) begin r = 1; d = cd; end
    else t = m_t[s];
  endfunction

  task automatic reset_model();
    for (int i = 0; i < 8; i++) begin m_v[i] = 1; m_t[i] = 0; m_d[i] = 0; end
    e_ok = 0; e_ar = 0; e_br = 0; e_dv = 0;
    e_ad = 0; e_bd = 0; e_dd = 0; e_at = 0; e_bt = 0; e_dt = 0;
  endtask

  // Called at a falling edge; drives one request and checks the registered response.
  task automatic cyc(input bit en, input bit fr, input logic [2:0] a, input logic [2:0] b,
                     input logic [2:0] d, input logic [3:0] t, input bit cv,
                     input logic [3:0] ct, input logic [15:0] cd, input logic [2:0] ds,
                     input string lbl);
    bit go;
    string ls, ld;
    ren_en = en; rs_free = fr; ren_src_a = a; ren_src_b = b; ren_dst = d; ren_tag = t;
    bc_valid = cv; bc_tag = ct; bc_data = cd; dbg_sel = ds;
    go = en && fr;
    e_ok = go;
    if (go) begin
      look(a, cv, ct, cd, e_ar, e_ad, e_at);
      look(b, cv, ct, cd, e_br, e_bd, e_bt);
    end
    e_dv = m_v[ds]; e_dd = m_d[ds]; e_dt = m_t[ds];
    @(posedge clk);
    for (int r = 0; r < 8; r++) begin
      if (go && d == 3'(r)) begin m_v[r] = 0; m_t[r] = t; end
      else if (cv && !m_v[r] && m_t[r] == ct) begin m_v[r] = 1; m_d[r] = cd; end
    end
    @(negedge clk);
    ls = (lbl != "") ? lbl : "R3";
    ld = (lbl != "") ? lbl : "R11";
    chk("R10 ren_ok", {31'd0, ren_ok}, {31'd0, e_ok});
    chk({ls, " a"}, {11'd0, src_a_ready, src_a_tag, src_a_data}, {11'd0, e_ar, e_at, e_ad});
    chk({ls, " b"}, {11'd0, src_b_ready, src_b_tag, src_b_data}, {11'd0, e_br, e_bt, e_bd});
    chk({ld, " dbg"}, {11'd0, dbg_valid, dbg_tag, dbg_data}, {11'd0, e_dv, e_dt, e_dd});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [3:0] tc;
    void'($urandom(32'h5eed));
    reset_model();
    repeat (3) @(posedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state, read through the debug port
    for (int i = 0; i < 8; i++) cyc(0, 1, 0, 0, 0, 0, 0, 0, 0, 3'(i), "R1");
    // R2: claim r3 with tag 5
    cyc(1, 1, 1, 2, 3, 4'd5, 0, 0, 0, 3, "R2");
    cyc(0, 1, 0, 0, 0, 0, 0, 0, 0, 3, "R2");
    // R5: second rename of r3, then broadcast of the older tag 5 must be dropped
    cyc(1, 1, 0, 0, 3, 4'd6, 0, 0, 0, 3, "R5");
    cyc(1, 1, 3, 3, 7, 4'd1, 1, 4'd5, 16'hdead, 3, "R5");
    cyc(0, 1, 0, 0, 0, 0, 0, 0, 0, 3, "R5");
    // R8: broadcast of tag 6 bypassed into a same-cycle lookup of r3; R4 capture
    cyc(1, 1, 3, 4, 6, 4'd2, 1, 4'd6, 16'h1234, 3, "R8");
    cyc(0, 1, 0, 0, 0, 0, 0, 0, 0, 3, "R4");
    // R7: r2 pending on tag 8, then rename r2 to tag 9 while tag 8 broadcasts
    cyc(1, 1, 0, 0, 2, 4'd8, 0, 0, 0, 2, "R7");
    cyc(1, 1, 0, 0, 2, 4'd9, 1, 4'd8, 16'hbeef, 2, "R7");
    cyc(0, 1, 0, 0, 0, 0, 0, 0, 0, 2, "R7");
    // R6: no free station, no change and outputs hold
    cyc(1, 0, 2, 2, 4, 4'd10, 0, 0, 0, 4, "R6");
    cyc(0, 1, 0, 0, 0, 0, 0, 0, 0, 4, "R6");
    // R9 / R12: sources equal the destination
    cyc(1, 1, 5, 5, 5, 4'd11, 0, 0, 0, 5, "R9");
    cyc(1, 1, 5, 5, 0, 4'd12, 0, 0, 0, 5, "R12");
    // Random phase
    tc = 4'd13;
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] rr;
      logic [3:0] ct;
      bit en, fr, cv;
      rr = 3'($urandom % 8);
      ct = ($urandom % 2) ? m_t[rr] : 4'($urandom);
      en = ($urandom % 3) != 0;
      fr = ($urandom % 4) != 0;
      cv = ($urandom % 2) != 0;
      cyc(en, fr, 3'($urandom), 3'($urandom), 3'($urandom), tc, cv, ct, 16'($urandom),
          3'($urandom), "");
      if (en && fr) tc = tc + 4'd1;
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule